// File: doc/BRIEF.md
# Multi-Level Transform Pass Sequencer

This block is the control unit for a separable two-dimensional transform that works line by line. One start request runs a number of decomposition levels. Each level has a row pass followed by a column pass. In every pass the block walks the lines of the current level in order. For each line it reads memory, kicks the arithmetic engine, waits for the engine's ready flag and then writes the result back. Each deeper level works on half as many lines as the level above it.

A small state machine does the sequencing. Its eight states carry fixed 4-bit codes. Two down-counters sit beside it: one counts the lines left in the current pass and one counts the levels left in the run. Every decision to leave a pass or to finish the run is a test of one of these counters for zero. Only one memory or engine strobe is active in any cycle, and each line is written exactly once per pass. As a result, no two accesses ever hit the same line in the same step. The level index and the line index are output so that the memory side can form addresses.

Top module: `xfm_seq`

## Requirements
- R1: Reset, which is asynchronous and active low, puts the machine in state code 0000 with mem_rd, eng_start, mem_wr and done all low.
- R2: The state code on seq_state follows this order only: 0000 -> 0001 -> 0010 -> 0100 -> 0101 -> 0110, then either 0010 (more lines) or 0111 (pass complete). From 0111 it goes to 0001 (next pass) or 0011 (run complete), and from 0011 it goes to 0000. The code 0000 may repeat while idle, and 0101 may repeat while the machine waits.
- R3: start is only sampled in state 0000. If start is low there, the machine stays in 0000. A start pulse in any other state has no effect on the sequence or its length.
- R4: Each line takes the following steps. mem_rd is high for one cycle (state 0010) and eng_start is high in the next cycle (0100). The block then waits in 0101 until eng_ready is high. mem_wr is high for one cycle (0110) in the cycle after that. A line therefore takes 4 + W cycles, where W is the number of cycles spent waiting with eng_ready low.
- R5: A pass at level k covers LINES >> k lines. cur_line counts 0, 1, 2, ... at each mem_wr of the pass.
- R6: Within a level, all writes with pass_sel = 0 (row pass) come first, followed by all writes with pass_sel = 1 (column pass). pass_sel changes only when leaving state 0111.
- R7: level_idx steps 0, 1, ..., L-1 across the run. L is the effective level count, and each level holds one row pass and one column pass. The total run length from state 0001 through 0011 is the sum over k of 2*(2 + (LINES>>k)*(4+W)) cycles, plus 1.
- R8: The effective level count L is taken from levels_req as follows. A request of 0 gives one level. A request above MAX_LEVELS gives MAX_LEVELS levels.
- R9: done is high for exactly one cycle (state 0011), and the machine is in 0000 in the following cycle, ready for a new start.
- R10: At most one of mem_rd, eng_start and mem_wr is high in any cycle.
- R11: eng_ready has no effect outside state 0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled in the idle state only |
| levels_req | input | LVL_W (3) | Requested number of decomposition levels |
| eng_ready | input | 1 | Engine has finished the current line |
| mem_rd | output | 1 | Read strobe for the current line |
| mem_wr | output | 1 | Write-back strobe for the current line |
| eng_start | output | 1 | One-cycle engine kick |
| pass_sel | output | 1 | 0 = row pass, 1 = column pass |
| level_idx | output | IDX_W (2) | Current decomposition level |
| cur_line | output | LINE_W (3) | Line index within the current pass |
| done | output | 1 | One-cycle run-complete pulse |
| seq_state | output | 4 | Current state code |

## Verification
Runs use level requests of 0, 1, 2, 3 and 7. These separate correct halving of the line count per level, and the two clamping limits, from a plain pass-through of the request. Engine latencies of 0, 1, 2 and 3 cycles show that the wait state holds on eng_ready and only there. Some runs keep eng_ready and start high in every other state. These runs must end with the exact same cycle count and write order as the clean runs, which proves both inputs are ignored outside their own states. A reset in the middle of a run, and back-to-back runs after done, check that the machine returns to idle and can start again.

// File: rtl/xfm_seq_pkg.sv
package xfm_seq_pkg;

   // State codes are fixed; the visiting order is part of the behaviour.
   typedef enum logic [3:0] {
      ST_IDLE  = 4'b0000,
      ST_INIT  = 4'b0001,
      ST_READ  = 4'b0010,
      ST_KICK  = 4'b0100,
      ST_WAIT  = 4'b0101,
      ST_WRITE = 4'b0110,
      ST_PEND  = 4'b0111,
      ST_DONE  = 4'b0011
   } seq_st_e;

   typedef enum logic {
      PASS_ROW = 1'b0,
      PASS_COL = 1'b1
   } pass_e;

endpackage

// File: rtl/xfm_seq_cnt.sv
module xfm_seq_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);

   generate
      if (W < 1) begin : g_bad_w
         $error("xfm_seq_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/xfm_seq_lvl.sv
module xfm_seq_lvl #(
   parameter int LVL_W      = 3,
   parameter int IDX_W      = 2,
   parameter int MAX_LEVELS = 3,
   parameter bit CLAMP_EN   = 1'b1
) (
   input  logic [LVL_W-1:0] req,
   output logic [IDX_W-1:0] lvl_m1
);

   generate
      if (CLAMP_EN) begin : g_clamp
         always_comb begin
            if (req == '0)
               lvl_m1 = '0;
            else if (req > LVL_W'(MAX_LEVELS))
               lvl_m1 = IDX_W'(MAX_LEVELS - 1);
            else
               lvl_m1 = IDX_W'(req - LVL_W'(1));
         end
      end else begin : g_raw
         assign lvl_m1 = IDX_W'(req - LVL_W'(1));
      end
   endgenerate

endmodule

// File: rtl/xfm_seq_fsm.sv
module xfm_seq_fsm
   import xfm_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    ready,
   input  logic    line_zero,
   input  logic    lvl_zero,
   output seq_st_e st_q,
   output pass_e   pass_q,
   output logic    ld_lvl,
   output logic    ld_line,
   output logic    dec_line,
   output logic    dec_lvl
);

   seq_st_e st_d;
   pass_e   pass_d;

   always_comb begin
      st_d   = st_q;
      pass_d = pass_q;
      case (st_q)
         ST_IDLE:  if (start) st_d = ST_INIT;
         ST_INIT:  st_d = ST_READ;
         ST_READ:  st_d = ST_KICK;
         ST_KICK:  st_d = ST_WAIT;
         ST_WAIT:  if (ready) st_d = ST_WRITE;
         ST_WRITE: st_d = line_zero ? ST_PEND : ST_READ;
         ST_PEND: begin
            if (pass_q == PASS_ROW) begin
               pass_d = PASS_COL;
               st_d   = ST_INIT;
            end else begin
               pass_d = PASS_ROW;
               st_d   = lvl_zero ? ST_DONE : ST_INIT;
            end
         end
         ST_DONE:  st_d = ST_IDLE;
         default: begin
            st_d   = ST_IDLE;
            pass_d = PASS_ROW;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pass_q <= PASS_ROW;
      end else begin
         st_q   <= st_d;
         pass_q <= pass_d;
      end
   end

   assign ld_lvl   = (st_q == ST_IDLE) && start;
   assign ld_line  = (st_q == ST_INIT);
   assign dec_line = (st_q == ST_WRITE) && !line_zero;
   assign dec_lvl  = (st_q == ST_PEND) && (pass_q == PASS_COL) && !lvl_zero;

endmodule

// File: rtl/xfm_seq.sv
module xfm_seq
   import xfm_seq_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int MAX_LEVELS = 3,
   parameter bit CLAMP_EN   = 1'b1,
   localparam int LINE_W    = $clog2(LINES),
   localparam int IDX_W     = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1,
   localparam int LVL_W     = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LVL_W-1:0]  levels_req,
   input  logic              eng_ready,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              eng_start,
   output logic              pass_sel,
   output logic [IDX_W-1:0]  level_idx,
   output logic [LINE_W-1:0] cur_line,
   output logic              done,
   output logic [3:0]        seq_state
);

   localparam logic [LINE_W:0] LINES_V = (LINE_W + 1)'(LINES);
   localparam logic [LINE_W:0] ONE_V   = (LINE_W + 1)'(1);

   generate
      if (LINES < 4 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("xfm_seq: LINES must be a power of two, at least 4");
      end
      if (MAX_LEVELS < 1 || MAX_LEVELS > LINE_W) begin : g_bad_levels
         $error("xfm_seq: MAX_LEVELS must lie in 1..log2(LINES)");
      end
   endgenerate

   seq_st_e           st_q;
   pass_e             pass_q;
   logic              ld_lvl, ld_line, dec_line, dec_lvl;
   logic              line_zero, lvl_zero;
   logic [IDX_W-1:0]  lvl_m1_req, lvlm1_q, lvl_cnt;
   logic [LINE_W:0]   lines_lvl, lines_m1;
   logic [LINE_W-1:0] line_ld_val, line_cnt;

   xfm_seq_lvl #(
      .LVL_W(LVL_W), .IDX_W(IDX_W), .MAX_LEVELS(MAX_LEVELS), .CLAMP_EN(CLAMP_EN)
   ) u_lvl (
      .req    (levels_req),
      .lvl_m1 (lvl_m1_req)
   );

   xfm_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ready     (eng_ready),
      .line_zero (line_zero),
      .lvl_zero  (lvl_zero),
      .st_q      (st_q),
      .pass_q    (pass_q),
      .ld_lvl    (ld_lvl),
      .ld_line   (ld_line),
      .dec_line  (dec_line),
      .dec_lvl   (dec_lvl)
   );

   // Levels still to run after the current one.
   xfm_seq_cnt #(.W(IDX_W)) u_lvl_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_lvl),
      .load_val (lvl_m1_req),
      .dec      (dec_lvl),
      .cnt      (lvl_cnt),
      .zero     (lvl_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvlm1_q <= '0;
      else if (ld_lvl) lvlm1_q <= lvl_m1_req;
   end

   assign level_idx   = lvlm1_q - lvl_cnt;
   assign lines_lvl   = LINES_V >> level_idx;
   assign lines_m1    = lines_lvl - ONE_V;
   assign line_ld_val = lines_m1[LINE_W-1:0];

   // Lines still to run in the current pass after the current one.
   xfm_seq_cnt #(.W(LINE_W)) u_line_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_line),
      .load_val (line_ld_val),
      .dec      (dec_line),
      .cnt      (line_cnt),
      .zero     (line_zero)
   );

   assign cur_line  = line_ld_val - line_cnt;
   assign mem_rd    = (st_q == ST_READ);
   assign eng_start = (st_q == ST_KICK);
   assign mem_wr    = (st_q == ST_WRITE);
   assign done      = (st_q == ST_DONE);
   assign pass_sel  = (pass_q == PASS_COL);
   assign seq_state = st_q;

endmodule

// File: rtl/xfm_seq_chk.sv
module xfm_seq_chk #(
   parameter int IDX_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             eng_ready,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             eng_start,
   input logic             pass_sel,
   input logic [IDX_W-1:0] level_idx,
   input logic             done,
   input logic [3:0]       seq_state
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (seq_state == 4'b0000 && !mem_rd && !mem_wr && !eng_start && !done));

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, eng_start, mem_wr}));

   // R4
   rd_then_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> eng_start);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'b0000 && !start) |=> seq_state == 4'b0000);

   // R11
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'b0101 && !eng_ready) |=> seq_state == 4'b0101);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && seq_state == 4'b0000));

   // R6
   pass_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_sel != $past(pass_sel)) |-> ($past(seq_state) == 4'b0111));

   // R7
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_idx != $past(level_idx)) |->
         (level_idx == IDX_W'($past(level_idx) + 1'b1) || level_idx == '0));

endmodule

bind xfm_seq xfm_seq_chk #(.IDX_W(IDX_W)) u_xfm_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .eng_ready (eng_ready),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .eng_start (eng_start),
   .pass_sel  (pass_sel),
   .level_idx (level_idx),
   .done      (done),
   .seq_state (seq_state)
);

// File: tb/xfm_seq_bench.sv
`timescale 1ns/1ps
module xfm_seq_bench;

   localparam int LINES  = 8;
   localparam int MAXL   = 3;
   localparam int NVEC   = 7;
   // Stimulus: requested levels, engine latency, noise on start/ready; expected level count.
   localparam int V_REQ  [NVEC] = '{1, 2, 3, 0, 7, 3, 2};
   localparam int V_DLY  [NVEC] = '{0, 0, 2, 1, 0, 3, 1};
   localparam int V_NOIS [NVEC] = '{0, 1, 0, 1, 0, 1, 0};
   localparam int V_EXPL [NVEC] = '{1, 2, 3, 1, 3, 3, 2};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] levels_req = 3'd1;
   logic       eng_ready = 1'b0;
   logic       mem_rd, mem_wr, eng_start, pass_sel, done;
   logic [1:0] level_idx;
   logic [2:0] cur_line;
   logic [3:0] seq_state;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   xfm_seq u_xfm_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .levels_req(levels_req),
      .eng_ready(eng_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .eng_start(eng_start), .pass_sel(pass_sel), .level_idx(level_idx),
      .cur_line(cur_line), .done(done), .seq_state(seq_state)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit legal_next(input logic [3:0] a, input logic [3:0] b);
      case (a)
         4'b0000: return (b == 4'b0000 || b == 4'b0001);
         4'b0001: return (b == 4'b0010);
         4'b0010: return (b == 4'b0100);
         4'b0100: return (b == 4'b0101);
         4'b0101: return (b == 4'b0101 || b == 4'b0110);
         4'b0110: return (b == 4'b0010 || b == 4'b0111);
         4'b0111: return (b == 4'b0001 || b == 4'b0011);
         4'b0011: return (b == 4'b0000);
         default: return 1'b0;
      endcase
   endfunction

   task automatic run(input int req, input int dly, input bit noise, input int expl);
      int e_l = 0, e_p = 0, e_i = 0;
      int n_wr = 0, exp_wr = 0, cyc = 0, exp_cyc = 1;
      int err_seq = 0, err_ord = 0, err_hs = 0, err_ex = 0, n_done = 0, max_l = 0;
      int wcnt = 0;
      bit want_kick = 0, prev_wr_ok = 0, prev_done = 0;
      logic [3:0] prev_st = 4'b0000;
      for (int k = 0; k < expl; k++) begin
         exp_wr  += 2 * (LINES >> k);
         exp_cyc += 2 * (2 + (LINES >> k) * (4 + dly));
      end
      @(negedge clk);
      levels_req = 3'(req);
      start = 1'b1;
      eng_ready = noise;
      for (int t = 0; t < 5000; t++) begin
         @(negedge clk);
         start = 1'b0;
         if (!legal_next(prev_st, seq_state)) err_seq++;
         if (seq_state != 4'b0000) cyc++;
         if (int'(mem_rd) + int'(eng_start) + int'(mem_wr) > 1) err_ex++;
         if (want_kick && !eng_start) err_hs++;
         want_kick = mem_rd;
         if (mem_wr) begin
            if (!prev_wr_ok) err_hs++;
            if (int'(pass_sel) != e_p || int'(level_idx) != e_l || int'(cur_line) != e_i)
               err_ord++;
            if (int'(level_idx) > max_l) max_l = int'(level_idx);
            n_wr++;
            e_i++;
            if (e_i == (LINES >> e_l)) begin
               e_i = 0;
               if (e_p == 0) e_p = 1;
               else begin e_p = 0; e_l++; end
            end
         end
         if (done) begin n_done++; if (prev_done) err_seq++; end
         prev_done = done;
         if (eng_start) wcnt = dly;
         if (seq_state == 4'b0101) begin
            eng_ready = (wcnt == 0);
            if (wcnt > 0) wcnt--;
         end else begin
            eng_ready = noise;
         end
         prev_wr_ok = (seq_state == 4'b0101) && eng_ready;
         if (noise && seq_state != 4'b0000) start = 1'b1;
         if (seq_state == 4'b0000 && prev_st == 4'b0011) break;
         prev_st = seq_state;
      end
      eng_ready = 1'b0;
      start = 1'b0;
      chk(err_seq == 0, "R2 state order", err_seq, 0);
      chk(err_hs == 0, "R4 rd/kick/ready/wr handshake", err_hs, 0);
      chk(n_wr == exp_wr, "R5 write count", n_wr, exp_wr);
      chk(err_ord == 0, "R6 pass/level/line order", err_ord, 0);
      chk(cyc == exp_cyc, "R7 R3 R11 run length", cyc, exp_cyc);
      chk(max_l + 1 == expl, "R8 effective levels", max_l + 1, expl);
      chk(n_done == 1, "R9 single done", n_done, 1);
      chk(err_ex == 0, "R10 strobe exclusive", err_ex, 0);
      chk(seq_state == 4'b0000, "R9 back to idle", int'(seq_state), 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(seq_state == 4'b0000, "R1 reset state", int'(seq_state), 0);
      chk({mem_rd, eng_start, mem_wr, done} == 4'b0, "R1 strobes low",
          int'({mem_rd, eng_start, mem_wr, done}), 0);
      rst_n = 1'b1;
      // R3: idle without start, ready high
      eng_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk(seq_state == 4'b0000 && !mem_rd, "R3 idle hold", int'(seq_state), 0);
      eng_ready = 1'b0;
      // Table walk
      for (int v = 0; v < NVEC; v++)
         run(V_REQ[v], V_DLY[v], V_NOIS[v] != 0, V_EXPL[v]);
      // R1: reset in mid-run
      @(negedge clk);
      levels_req = 3'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(negedge clk);
      chk(seq_state != 4'b0000, "R1 run active before reset", int'(seq_state), 5);
      #1 rst_n = 1'b0;
      #1;
      chk(seq_state == 4'b0000 && {mem_rd, eng_start, mem_wr, done} == 4'b0,
          "R1 mid-run reset", int'(seq_state), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // Recovery after reset, R8 clamp again
      run(0, 0, 1'b0, 1);
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule